// File: doc/BRIEF.md
# Memory-Mapped Bidirectional GPIO Port

This block is one 8-bit general-purpose I/O port placed behind a small register bus. Five registers control it. The first is a pin-level view: writing it loads the output latch, and reading it returns the synchronized pin levels. The second is the output latch itself. The others are a direction register, an analog-select register and a slew-rate register. The block drives output data, output enables, analog-select and slew controls to the pad buffers. It samples each pad's input level through a two-flop synchronizer.

A configuration input can give the two upper pins to an oscillator. While it is asserted, those pins have their output enables forced off and their output data held low. Their bits also read as zero through the pin view, the latch and the direction register. The stored register contents are kept, so they come back when the claim is released. Pins with their analog-select bit set read as zero through the pin view. The analog-select bit does not change that pin's output enable. The direction register alone decides that.

Top module: `gpio_port`

## Requirements
- R1: After reset the direction register reads 8'hFF (all inputs), the latch reads 8'h00, the analog-select register reads 8'h2F (pins 5 and 3..0 analog, pin 4 digital), the slew register reads 8'h00, and every output enable is 0.
- R2: A write at address 0 or address 1 loads the output latch on the clock edge. A read at address 1 returns the latch, not the pin levels.
- R3: A direction bit of 1 makes that pin's output enable 0. A direction bit of 0 makes it 1. The latch bit drives the pin's output data. A read at address 2 returns the direction register.
- R4: A read at address 0 returns the pin levels through a two-flop synchronizer. A pin change made before clock edge k becomes visible after edge k+1 and not before.
- R5: A pin whose analog-select bit is 1 reads as 0 at address 0. The analog-select bits have no effect on the output enables.
- R6: While osc_claim is 1, pins 7 and 6 have output enable 0 and output data 0. Bits 7:6 read as 0 at addresses 0, 1 and 2, whatever is stored in those registers.
- R7: Address 3 (analog select) and address 4 (slew rate) are written and read back unchanged. They drive pin_analog and pin_slew directly.
- R8: Writes to addresses 5, 6 and 7 change no register, and reads of those addresses return 0.
- R9: Writes to the bits of claimed pins are still stored. After osc_claim returns to 0, those bits read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous assert |
| bus_wr | input | 1 | Write strobe, takes effect at the clock edge |
| bus_addr | input | 3 | Register select: 0 pin view, 1 latch, 2 direction, 3 analog, 4 slew |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| osc_claim | input | 1 | Hands pins 7:6 to the oscillator when 1 |
| pin_in | input | 8 | Pad input levels, asynchronous |
| pin_out | output | 8 | Pad output data |
| pin_oe | output | 8 | Pad output enables, 1 = driving |
| pin_analog | output | 8 | Per-pin analog select to the pads |
| pin_slew | output | 8 | Per-pin slew-rate control to the pads |

## Verification
Every one of the 256 direction values is written against a fixed latch pattern. This separates the output-enable polarity from the output-data path. The 256 pin values are swept under four analog-select masks (none, reset default, upper nibble, all). Each pin change is read once after one clock and once after two. This separates the analog masking from the synchronizer latency, and off-by-one stage counts from masking faults. The latch is swept through both write addresses while the pins hold the complement value, which tells a latch read apart from a pin read. The oscillator claim is tested with the upper registers holding ones and with writes made during the claim, which shows whether the masking acts at the read path or on the stored state.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    SEL_PIN    = 3'd0,
    SEL_LATCH  = 3'd1,
    SEL_DIR    = 3'd2,
    SEL_ANALOG = 3'd3,
    SEL_SLEW   = 3'd4
  } reg_sel_e;

  function automatic logic sel_mapped(input logic [ADDR_W-1:0] a);
    return a <= 3'd4;
  endfunction

  function automatic logic sel_loads_latch(input logic [ADDR_W-1:0] a);
    return (a == SEL_PIN) || (a == SEL_LATCH);
  endfunction

  function automatic logic sel_masked_high(input logic [ADDR_W-1:0] a);
    return (a == SEL_PIN) || (a == SEL_LATCH) || (a == SEL_DIR);
  endfunction

endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int          WIDTH   = 8,
  parameter logic [WIDTH-1:0] ANA_RST = 8'h2F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WIDTH-1:0]  wr_data,
  output logic [WIDTH-1:0]  lat_q,
  output logic [WIDTH-1:0]  dir_q,
  output logic [WIDTH-1:0]  ana_q,
  output logic [WIDTH-1:0]  slew_q
);

  logic hit_lat, hit_dir, hit_ana, hit_slew, hit_none;

  assign hit_lat  = wr_en && sel_loads_latch(wr_addr);
  assign hit_dir  = wr_en && (wr_addr == SEL_DIR);
  assign hit_ana  = wr_en && (wr_addr == SEL_ANALOG);
  assign hit_slew = wr_en && (wr_addr == SEL_SLEW);
  assign hit_none = wr_en && !sel_mapped(wr_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q  <= '0;
      dir_q  <= '1;
      ana_q  <= ANA_RST;
      slew_q <= '0;
    end else begin
      if (hit_lat)  lat_q  <= wr_data;
      if (hit_dir)  dir_q  <= wr_data;
      if (hit_ana)  ana_q  <= wr_data;
      if (hit_slew) slew_q <= wr_data;
    end
  end

  // R2: both latch aliases load the written value
  assert_latch_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel_loads_latch(wr_addr)) |=> (lat_q == $past(wr_data)));

  // R3: direction only moves on its own write
  assert_dir_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (wr_addr == SEL_DIR)) |=> $stable(dir_q));

  // R8: unmapped writes leave all state unchanged
  assert_unmapped_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hit_none |=> $stable({lat_q, dir_q, ana_q, slew_q}));

endmodule

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage[s] <= '0;
    end else begin
      stage[0] <= d;
      for (int s = 1; s < STAGES; s++) stage[s] <= stage[s-1];
    end
  end

  assign q = stage[STAGES-1];

endmodule

// File: rtl/gpio_port_rdmux.sv
module gpio_port_rdmux
  import gpio_port_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  pin_s,
  input  logic [WIDTH-1:0]  lat_q,
  input  logic [WIDTH-1:0]  dir_q,
  input  logic [WIDTH-1:0]  ana_q,
  input  logic [WIDTH-1:0]  slew_q,
  input  logic [WIDTH-1:0]  osc_mask,
  output logic [WIDTH-1:0]  rdata
);

  function automatic logic [WIDTH-1:0] view_pins(
    input logic [WIDTH-1:0] pins, input logic [WIDTH-1:0] ana,
    input logic [WIDTH-1:0] mask);
    return pins & ~ana & ~mask;
  endfunction

  function automatic logic [WIDTH-1:0] view_owned(
    input logic [WIDTH-1:0] v, input logic [WIDTH-1:0] mask);
    return v & ~mask;
  endfunction

  always_comb begin
    unique case (addr)
      SEL_PIN:    rdata = view_pins(pin_s, ana_q, osc_mask);
      SEL_LATCH:  rdata = view_owned(lat_q, osc_mask);
      SEL_DIR:    rdata = view_owned(dir_q, osc_mask);
      SEL_ANALOG: rdata = ana_q;
      SEL_SLEW:   rdata = slew_q;
      default:    rdata = '0;
    endcase
  end

endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int               WIDTH       = 8,
  parameter int               OSC_LSB     = 6,
  parameter int               OSC_PINS    = 2,
  parameter int               SYNC_STAGES = 2,
  parameter logic [WIDTH-1:0] ANA_RST     = 8'h2F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic              osc_claim,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  pin_out,
  output logic [WIDTH-1:0]  pin_oe,
  output logic [WIDTH-1:0]  pin_analog,
  output logic [WIDTH-1:0]  pin_slew
);

  logic [WIDTH-1:0] lat_q, dir_q, ana_q, slew_q, pin_s;
  logic [WIDTH-1:0] osc_mask;

  for (genvar b = 0; b < WIDTH; b++) begin : g_osc
    if (b >= OSC_LSB && b < OSC_LSB + OSC_PINS) begin : g_claimed
      assign osc_mask[b] = osc_claim;
    end else begin : g_free
      assign osc_mask[b] = 1'b0;
    end
  end

  gpio_port_regs #(.WIDTH(WIDTH), .ANA_RST(ANA_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .wr_addr(bus_addr),
    .wr_data(bus_wdata), .lat_q(lat_q), .dir_q(dir_q),
    .ana_q(ana_q), .slew_q(slew_q)
  );

  gpio_port_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_s)
  );

  gpio_port_rdmux #(.WIDTH(WIDTH)) u_rdmux (
    .addr(bus_addr), .pin_s(pin_s), .lat_q(lat_q), .dir_q(dir_q),
    .ana_q(ana_q), .slew_q(slew_q), .osc_mask(osc_mask), .rdata(bus_rdata)
  );

  assign pin_oe     = ~dir_q & ~osc_mask;
  assign pin_out    = lat_q & ~osc_mask;
  assign pin_analog = ana_q;
  assign pin_slew   = slew_q;

  // cycles since reset, saturating, for the latency check
  logic [1:0] warm;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm <= '0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  // R5: analog pins never show a one in the pin view
  assert_analog_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == SEL_PIN) |-> ((bus_rdata & pin_analog) == '0));

  // R6: claimed pins are quiet on the pads and in the masked views
  assert_osc_pads_R6: assert property (@(posedge clk) disable iff (!rst_n)
    osc_claim |-> (((pin_oe | pin_out) & osc_mask) == '0));
  assert_osc_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_claim && sel_masked_high(bus_addr)) |-> ((bus_rdata & osc_mask) == '0));

  // R3: a direction write sets the enables one cycle later
  assert_dir_to_oe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == SEL_DIR && !osc_claim) ##1 !osc_claim
      |-> (pin_oe == ~$past(bus_wdata)));

  if (SYNC_STAGES == 2) begin : g_lat_chk
    // R4: pin view lags the pads by exactly two edges
    assert_sync_lag_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (warm == 2'd3 && bus_addr == SEL_PIN)
        |-> (bus_rdata == ($past(pin_in, 2) & ~pin_analog & ~osc_mask)));
  end

endmodule

// File: tb/test_gpio_port.sv
`timescale 1ns/1ps
module test_gpio_port;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       osc_claim = 1'b0;
  logic [7:0] pin_in = 8'h00;
  logic [7:0] pin_out, pin_oe, pin_analog, pin_slew;

  int vectors = 0;
  int errors  = 0;

  always #4 clk = ~clk;

  gpio_port i_gpio_port (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .osc_claim(osc_claim),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .pin_analog(pin_analog), .pin_slew(pin_slew)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  function automatic logic [7:0] hi_mask(input logic claim);
    return claim ? 8'hC0 : 8'h00;
  endfunction

  logic [7:0] v;
  logic [7:0] prev;
  logic [7:0] amask [4] = '{8'h00, 8'h2F, 8'hF0, 8'hFF};

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(3'd0, v); chk("R1 pin view", v, 8'h00);
    rd(3'd1, v); chk("R1 latch", v, 8'h00);
    rd(3'd2, v); chk("R1 dir", v, 8'hFF);
    rd(3'd3, v); chk("R1 analog", v, 8'h2F);
    rd(3'd4, v); chk("R1 slew", v, 8'h00);
    chk("R1 oe", pin_oe, 8'h00);
    chk("R1 pin_analog", pin_analog, 8'h2F);

    // R8 unmapped addresses
    for (int a = 5; a < 8; a++) begin
      wr(a[2:0], 8'h5A);
      rd(a[2:0], v); chk("R8 unmapped read", v, 8'h00);
    end
    rd(3'd1, v); chk("R8 latch kept", v, 8'h00);
    rd(3'd2, v); chk("R8 dir kept", v, 8'hFF);
    rd(3'd3, v); chk("R8 analog kept", v, 8'h2F);
    rd(3'd4, v); chk("R8 slew kept", v, 8'h00);

    // R7 analog and slew read/write
    for (int i = 0; i < 256; i++) begin
      wr(3'd3, i[7:0]); rd(3'd3, v); chk("R7 analog rw", v, i[7:0]);
      chk("R7 pin_analog", pin_analog, i[7:0]);
      wr(3'd4, ~i[7:0]); rd(3'd4, v); chk("R7 slew rw", v, ~i[7:0]);
      chk("R7 pin_slew", pin_slew, ~i[7:0]);
    end
    wr(3'd3, 8'h00);

    // R2 latch via both addresses, pins hold the complement
    for (int i = 0; i < 256; i++) begin
      pin_in = ~i[7:0];
      wr(i[0] ? 3'd0 : 3'd1, i[7:0]);
      rd(3'd1, v); chk("R2 latch read", v, i[7:0]);
      rd(3'd0, v); chk("R2 pin view differs", v, ~i[7:0]);
    end

    // R3 direction sweep
    wr(3'd1, 8'hA5);
    for (int i = 0; i < 256; i++) begin
      wr(3'd2, i[7:0]);
      chk("R3 oe", pin_oe, ~i[7:0]);
      chk("R3 out", pin_out, 8'hA5);
      rd(3'd2, v); chk("R3 dir read", v, i[7:0]);
    end

    // R4/R5 pin sweep under analog masks, latency checked per change
    for (int m = 0; m < 4; m++) begin
      wr(3'd3, amask[m]);
      @(negedge clk); @(negedge clk);
      prev = pin_in;
      for (int p = 0; p < 256; p++) begin
        pin_in = p[7:0];
        @(negedge clk);
        rd(3'd0, v); chk("R4 one edge old", v, prev & ~amask[m]);
        @(negedge clk);
        rd(3'd0, v); chk("R5 two edges new", v, p[7:0] & ~amask[m]);
        prev = p[7:0];
      end
    end

    // R5 analog leaves enables alone
    wr(3'd3, 8'hFF);
    wr(3'd2, 8'h00);
    chk("R5 oe with analog", pin_oe, 8'hFF);
    wr(3'd3, 8'h00);

    // R6 oscillator claim
    wr(3'd1, 8'hFF);
    pin_in = 8'hFF;
    osc_claim = 1'b1;
    @(negedge clk); @(negedge clk); @(negedge clk);
    chk("R6 oe", pin_oe, 8'hFF & ~hi_mask(1'b1));
    chk("R6 out", pin_out, 8'h3F);
    rd(3'd1, v); chk("R6 latch read", v, 8'h3F);
    rd(3'd0, v); chk("R6 pin view", v, 8'h3F);
    wr(3'd2, 8'hFF);
    rd(3'd2, v); chk("R6 dir read", v, 8'h3F);
    chk("R6 oe all inputs", pin_oe, 8'h00);

    // R9 writes during claim kept
    wr(3'd1, 8'hC3);
    wr(3'd2, 8'h81);
    osc_claim = 1'b0;
    #1;
    rd(3'd1, v); chk("R9 latch restored", v, 8'hC3);
    rd(3'd2, v); chk("R9 dir restored", v, 8'h81);
    chk("R9 oe restored", pin_oe, 8'h7E);
    chk("R9 out restored", pin_out, 8'hC3);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    vectors++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule